// File: doc/BRIEF.md
# Per-Lane Two-Bit Immediate Expander

This block turns one 32-bit load-immediate word into a vector of sixteen 32-bit lane values. In the two per-lane modes, each lane takes a 2-bit value. The lower half of the word supplies the low bit of every lane, and the upper half supplies the high bit. The pair is read either as an unsigned number from 0 to 3 or as a two's-complement number from -2 to 1. The result is widened to the full lane width by zero extension or by sign extension. A broadcast mode copies the whole word into every lane. The fourth mode code is reserved: it yields all-zero lanes and raises an error flag.

A one-cycle strobe presents the word and the mode. The result shows on the outputs in the next cycle, together with an output valid flag. While no strobe arrives, the lane outputs and the error flag keep their last values and the valid flag stays low.

The output side is a two-state machine. State `OUT_IDLE` means no fresh result. State `OUT_FRESH` means the result captured at the last edge is new. The transition `T_CAPTURE` (a strobe in either state) leads to `OUT_FRESH`. The transition `T_DRAIN` (no strobe in either state) leads to `OUT_IDLE`. Reset enters `OUT_IDLE`.

Top module: `lane_imm_expander`

## Requirements
- R1: After reset, `out_valid` is 0, every lane of `out_lanes` is 0 and `mode_err` is 0.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 in the cycle after a cycle with `in_valid` low.
- R3: In mode 0 (broadcast), every lane equals `imm_word`.
- R4: In mode 2 (per-lane unsigned), lane i (i = 0..15) equals the value {`imm_word[i+16]`, `imm_word[i]`}, zero-extended to 32 bits. For example, 0x00010001 gives lane 0 the value 3, and 0x80000000 gives lane 15 the value 2.
- R5: In mode 1 (per-lane signed), lane i equals the same bit pair read as two's complement and sign-extended to 32 bits. For example, 0x00008000 gives lane 15 the value 1, 0x80000000 gives -2 (0xFFFFFFFE) and 0x80008000 gives -1.
- R6: In mode 3 (reserved), every lane is 0 and `mode_err` is 1.
- R7: In modes 0, 1 and 2, `mode_err` is 0.
- R8: While `in_valid` is low, `out_lanes` and `mode_err` keep their values, whatever `imm_word` and `mode` carry.
- R9: Strobes on consecutive cycles each produce their own result one cycle later, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that presents a word and a mode |
| imm_word | input | 32 | Immediate word to expand |
| mode | input | 2 | 0 broadcast, 1 per-lane signed, 2 per-lane unsigned, 3 reserved |
| out_valid | output | 1 | High for one cycle after each strobe |
| out_lanes | output | 512 | Lane i is held in bits [32*i+31 : 32*i] |
| mode_err | output | 1 | Set by a reserved-mode strobe |

## Verification
The case hardest to reach from the ports is the hold behaviour. Idle cycles must leave the lanes and the error flag untouched even when the word and mode inputs keep changing. The bench captures a known result, then drives several idle cycles with a different word and the reserved mode on the inputs, and confirms that nothing moves. Back-to-back strobes that switch between the signed and unsigned modes check that the sign bit of one result does not leak into the next.

// File: rtl/lane_imm_pkg.sv
package lane_imm_pkg;

    typedef enum logic [1:0] {
        MODE_BCAST = 2'd0,
        MODE_SLANE = 2'd1,
        MODE_ULANE = 2'd2,
        MODE_RSVD  = 2'd3
    } imm_mode_e;

    typedef struct packed {
        logic bcast;
        logic sgn;
        logic uns;
        logic rsvd;
    } lane_sel_t;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_FRESH = 1'b1
    } out_state_e;

endpackage

// File: rtl/lane_imm_mode_dec.sv
module lane_imm_mode_dec
    import lane_imm_pkg::*;
(
    input  logic [1:0] mode_raw,
    output lane_sel_t  sel
);

    imm_mode_e mode_q;

    always_comb begin
        mode_q = imm_mode_e'(mode_raw);
        sel    = '0;
        unique case (mode_q)
            MODE_BCAST: sel.bcast = 1'b1;
            MODE_SLANE: sel.sgn   = 1'b1;
            MODE_ULANE: sel.uns   = 1'b1;
            MODE_RSVD:  sel.rsvd  = 1'b1;
        endcase
    end

endmodule

// File: rtl/lane_imm_lane.sv
module lane_imm_lane
    import lane_imm_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int IMM_W  = 32
) (
    input  logic [IMM_W-1:0]  word,
    input  logic              bit_lo,
    input  logic              bit_hi,
    input  lane_sel_t         sel,
    output logic [LANE_W-1:0] value
);

    localparam int EXT_W = LANE_W - 2;

    logic [LANE_W-1:0] bcast_val;
    logic [LANE_W-1:0] sgn_val;
    logic [LANE_W-1:0] uns_val;

    always_comb begin
        bcast_val = LANE_W'(word);
        sgn_val   = {{EXT_W{bit_hi}}, bit_hi, bit_lo};
        uns_val   = {{EXT_W{1'b0}}, bit_hi, bit_lo};
    end

    always_comb begin
        value = '0;
        unique case (1'b1)
            sel.bcast: value = bcast_val;
            sel.sgn:   value = sgn_val;
            sel.uns:   value = uns_val;
            sel.rsvd:  value = '0;
            default:   value = '0;
        endcase
    end

endmodule

// File: rtl/lane_imm_expander.sv
module lane_imm_expander
    import lane_imm_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int LANE_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [2*LANES-1:0]        imm_word,
    input  logic [1:0]                mode,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   out_lanes,
    output logic                      mode_err
);

    localparam int IMM_W = 2 * LANES;
    localparam int VEC_W = LANES * LANE_W;

    lane_sel_t          sel;
    logic [VEC_W-1:0]   lanes_nx;
    out_state_e         state_q;
    out_state_e         state_nx;

    lane_imm_mode_dec u_dec (
        .mode_raw (mode),
        .sel      (sel)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_imm_lane #(
            .LANE_W (LANE_W),
            .IMM_W  (IMM_W)
        ) u_lane (
            .word   (imm_word),
            .bit_lo (imm_word[g]),
            .bit_hi (imm_word[g+LANES]),
            .sel    (sel),
            .value  (lanes_nx[g*LANE_W +: LANE_W])
        );
    end

    // Next-state logic: T_CAPTURE on strobe, T_DRAIN otherwise
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            OUT_IDLE:  state_nx = in_valid ? OUT_FRESH : OUT_IDLE;
            OUT_FRESH: state_nx = in_valid ? OUT_FRESH : OUT_IDLE;
            default:   state_nx = OUT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_lanes <= '0;
            mode_err  <= 1'b0;
        end else if (in_valid) begin
            out_lanes <= lanes_nx;
            mode_err  <= sel.rsvd;
        end
    end

    assign out_valid = (state_q == OUT_FRESH);

endmodule

// File: rtl/lane_imm_expander_chk.sv
module lane_imm_expander_chk #(
    parameter int LANES  = 16,
    parameter int LANE_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [2*LANES-1:0]      imm_word,
    input logic [1:0]              mode,
    input logic                    out_valid,
    input logic [LANES*LANE_W-1:0] out_lanes,
    input logic                    mode_err
);

    logic seen_edge;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_edge <= 1'b0;
        else        seen_edge <= 1'b1;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                            // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                          // R2
    AST_BCAST_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd0) |=>
            out_lanes[LANE_W-1:0] == LANE_W'($past(imm_word)));              // R3
    AST_SIGNED_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd1) |=>
            (out_lanes[LANE_W-1:1] == '0 || out_lanes[LANE_W-1:1] == '1));   // R5
    AST_UNSIGNED_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd2) |=> out_lanes[LANE_W-1:2] == '0);         // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd3) |=> (out_lanes == '0 && mode_err));       // R6
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode != 2'd3) |=> !mode_err);                          // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && !in_valid) |=> ($stable(out_lanes) && $stable(mode_err))); // R8

endmodule

bind lane_imm_expander lane_imm_expander_chk #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .imm_word  (imm_word),
    .mode      (mode),
    .out_valid (out_valid),
    .out_lanes (out_lanes),
    .mode_err  (mode_err)
);

// File: tb/lane_imm_expander_tb.sv
module lane_imm_expander_tb;

    localparam int LANES  = 16;
    localparam int LANE_W = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic [2*LANES-1:0]      imm_word = '0;
    logic [1:0]              mode = 2'd0;
    logic                    out_valid;
    logic [LANES*LANE_W-1:0] out_lanes;
    logic                    mode_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    lane_imm_expander #(.LANES(LANES), .LANE_W(LANE_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .imm_word  (imm_word),
        .mode      (mode),
        .out_valid (out_valid),
        .out_lanes (out_lanes),
        .mode_err  (mode_err)
    );

    function automatic logic [31:0] exp_lane(input logic [31:0] w,
                                             input logic [1:0] m, input int i);
        logic lo;
        logic hi;
        lo = w[i];
        hi = w[i+16];
        case (m)
            2'd0:    return w;
            2'd1:    return hi ? (lo ? 32'hFFFF_FFFF : 32'hFFFF_FFFE) : {31'b0, lo};
            2'd2:    return {30'b0, hi, lo};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check1(input string req, input logic [31:0] act,
                          input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [31:0] w,
                             input logic [1:0] m);
        for (int i = 0; i < LANES; i++)
            check1(req, out_lanes[i*LANE_W +: LANE_W], exp_lane(w, m, i));
        check1(req, {31'b0, mode_err}, {31'b0, (m == 2'd3)});
    endtask

    // Drive one strobe at a falling edge; the result is read at the next falling edge
    task automatic strobe(input logic [31:0] w, input logic [1:0] m);
        @(negedge clk);
        in_valid = 1'b1;
        imm_word = w;
        mode     = m;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R1", {31'b0, out_valid}, 32'd0);
        check1("R1", {31'b0, mode_err}, 32'd0);
        for (int i = 0; i < LANES; i++)
            check1("R1", out_lanes[i*LANE_W +: LANE_W], 32'd0);
    endtask

    task automatic t_broadcast;
        strobe(32'hDEAD_BEEF, 2'd0);
        check1("R2", {31'b0, out_valid}, 32'd1);
        check_vec("R3", 32'hDEAD_BEEF, 2'd0);
        check_vec("R7", 32'hDEAD_BEEF, 2'd0);
        @(negedge clk);
        check1("R2", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_unsigned;
        logic [31:0] pats [4] = '{32'h0000_0001, 32'h0001_0000,
                                  32'h0001_0001, 32'h8000_0000};
        foreach (pats[k]) begin
            strobe(pats[k], 2'd2);
            check_vec("R4", pats[k], 2'd2);
        end
        strobe(32'h0001_0001, 2'd2);
        check1("R4", out_lanes[31:0], 32'd3);
        strobe(32'h8000_0000, 2'd2);
        check1("R4", out_lanes[15*32 +: 32], 32'd2);
    endtask

    task automatic t_signed;
        logic [31:0] pats [4] = '{32'h0000_8000, 32'h8000_0000,
                                  32'h8000_8000, 32'hA5C3_5A3C};
        foreach (pats[k]) begin
            strobe(pats[k], 2'd1);
            check_vec("R5", pats[k], 2'd1);
        end
        strobe(32'h8000_8000, 2'd1);
        check1("R5", out_lanes[15*32 +: 32], 32'hFFFF_FFFF);
        check1("R7", {31'b0, mode_err}, 32'd0);
    endtask

    task automatic t_reserved;
        strobe(32'hFFFF_FFFF, 2'd3);
        check_vec("R6", 32'hFFFF_FFFF, 2'd3);
        strobe(32'h1234_5678, 2'd0);
        check1("R7", {31'b0, mode_err}, 32'd0);
    endtask

    task automatic t_hold;
        strobe(32'h0003_0002, 2'd2);
        check_vec("R8", 32'h0003_0002, 2'd2);
        for (int c = 0; c < 4; c++) begin
            imm_word = 32'hFFFF_FFFF - c;
            mode     = 2'd3;
            @(negedge clk);
            check_vec("R8", 32'h0003_0002, 2'd2);
            check1("R8", {31'b0, out_valid}, 32'd0);
        end
    endtask

    task automatic t_b2b;
        @(negedge clk);
        in_valid = 1'b1; imm_word = 32'hFFFF_0000; mode = 2'd1;
        @(negedge clk);
        check_vec("R9", 32'hFFFF_0000, 2'd1);
        check1("R9", {31'b0, out_valid}, 32'd1);
        imm_word = 32'hFFFF_0000; mode = 2'd2;
        @(negedge clk);
        check_vec("R9", 32'hFFFF_0000, 2'd2);
        check1("R9", {31'b0, out_valid}, 32'd1);
        imm_word = 32'h0000_FFFF; mode = 2'd3;
        @(negedge clk);
        in_valid = 1'b0;
        check_vec("R9", 32'h0000_FFFF, 2'd3);
        @(negedge clk);
        check1("R2", {31'b0, out_valid}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_broadcast();
        t_unsigned();
        t_signed();
        t_reserved();
        t_hold();
        t_b2b();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule